// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block turns bus addresses that land inside a graphics aperture window into physical addresses. The window starts at a 4 MB aligned base and has one of four sizes. A size code selects the size. Translation takes two steps. First, an on-chip directory picks a second-level table page in system memory. Second, one 32-bit entry of that page gives the physical page frame. Software loads the directory one entry at a time, each through a single packed register write.

A small fully associative cache holds recent translations, so repeated pages skip the memory read. Software empties this cache with two writes to a control register: the first clears the flush bit, the second sets it. Each accepted request ends in exactly one response. The response carries a translated address, a fault flag or an out-of-range flag. While a table read is outstanding, the block holds its request-ready output low.

Top module: `aperture_xlat`

## Requirements
- R1: A directory write carries the target entry number in bits 5:0, the present flag in bit 8, and the 4 KB aligned second-level page base in bits 31:12. Bits 11:9 and 7:6 are ignored. A write with bit 8 clear makes the selected entry not present.
- R2: Inside the window, the directory entry number is address bits 31:22 minus base bits 31:22, and the table entry number is address bits 21:12. The memory read address is {page base, address bits 21:12, 2'b00}.
- R3: The window covers a number of directory entries set by the size code: code 0 gives 64, code 32 gives 32, code 48 gives 16 and code 56 gives 8. Any other code treats every address as out of range.
- R4: An address below the base, or past the last directory entry in use, is answered with the out-of-range flag set, the fault flag clear and no memory read. This check takes priority over a cache hit.
- R5: An in-range address whose directory entry is not present is answered with the fault flag set and no memory read.
- R6: A second-level entry with bit 0 set gives the address {entry bits 31:12, request bits 11:0}. An entry with bit 0 clear gives a fault with address zero, and it is not cached. Every fault or out-of-range response carries address zero.
- R7: At most one memory read is outstanding. The read request stays high, with a stable address, until the read data returns. Request-ready is low for the whole time the read is outstanding.
- R8: A cache hit is answered without a memory read. The cache holds 4 translations and replaces them in round-robin order, so a fifth distinct page evicts the oldest fill.
- R9: A control write with bit 7 set flushes the whole cache, but only if the previous control write had bit 7 clear. Repeating a write with bit 7 set, or writing bit 7 clear alone, keeps the cached translations.
- R10: After reset, no response and no memory read are pending, and request-ready is high. A hit, an out-of-range answer or a directory fault responds in the cycle after the request is accepted. A walk responds in the cycle after the read data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aper_base_i | input | 32 | Aperture base address (bits 31:22 used) |
| aper_code_i | input | 8 | Aperture size code |
| dir_wr_i | input | 1 | Directory write strobe |
| dir_wdata_i | input | 32 | Packed directory write value |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 32 | Control write value (bit 7 is the flush bit) |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | 32 | Bus address to translate |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_addr_o | output | 32 | Translated address |
| rsp_fault_o | output | 1 | Translation fault |
| rsp_range_o | output | 1 | Address outside the window |
| mem_req_o | output | 1 | Second-level read request |
| mem_addr_o | output | 32 | Second-level entry address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Second-level entry read data |

## Verification
The bench builds the block with its defaults: a 64-entry directory and a 4-entry translation cache. With 64 entries, the last directory slot and the largest window are both reachable, so the index subtraction is tested at its top edge. With 4 cache entries, a fifth distinct page forces an eviction within a handful of requests. This lets the round-robin order and the flush rules be observed through which requests trigger a memory read.

// File: rtl/apx_pkg.sv
package apx_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned PAGE_W   = 12;
  localparam int unsigned DIR_LSB  = 22;
  localparam int unsigned VPN_W    = ADDR_W - PAGE_W;
  localparam int unsigned WIN_W    = ADDR_W - DIR_LSB;
  localparam int unsigned SEL_W    = 6;
  localparam int unsigned PRES_BIT = 8;
  localparam int unsigned FLUSH_BIT = 7;

  localparam logic [7:0] CODE_256M = 8'd0;
  localparam logic [7:0] CODE_128M = 8'd32;
  localparam logic [7:0] CODE_64M  = 8'd48;
  localparam logic [7:0] CODE_32M  = 8'd56;

  typedef enum logic [0:0] {ST_IDLE, ST_WALK} walk_state_e;

  typedef struct packed {
    logic             present;
    logic [VPN_W-1:0] base;
  } dir_entry_t;
endpackage

// File: rtl/apx_window.sv
module apx_window
  import apx_pkg::*;
#(
  parameter int unsigned DIR_ENTRIES = 64
) (
  input  logic [7:0]                       code_i,
  input  logic [WIN_W-1:0]                 base_hi_i,
  input  logic [WIN_W-1:0]                 addr_hi_i,
  output logic                             in_range_o,
  output logic [$clog2(DIR_ENTRIES)-1:0]   dir_idx_o
);
  localparam int unsigned IDX_W = $clog2(DIR_ENTRIES);
  localparam int unsigned CNT_W = IDX_W + 1;

  logic [CNT_W-1:0] used_cnt;
  logic [WIN_W:0]   diff;

  always_comb begin
    unique case (code_i)
      CODE_256M: used_cnt = CNT_W'(DIR_ENTRIES);
      CODE_128M: used_cnt = CNT_W'(DIR_ENTRIES / 2);
      CODE_64M:  used_cnt = CNT_W'(DIR_ENTRIES / 4);
      CODE_32M:  used_cnt = CNT_W'(DIR_ENTRIES / 8);
      default:   used_cnt = '0;
    endcase
  end

  // borrow bit flags addresses below the base
  assign diff       = {1'b0, addr_hi_i} - {1'b0, base_hi_i};
  assign in_range_o = !diff[WIN_W] && (diff[WIN_W-1:0] < WIN_W'(used_cnt));
  assign dir_idx_o  = diff[IDX_W-1:0];
endmodule

// File: rtl/apx_dir.sv
module apx_dir
  import apx_pkg::*;
#(
  parameter int unsigned ENTRIES = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_data_i,
  input  logic [$clog2(ENTRIES)-1:0]   rd_idx_i,
  output dir_entry_t                   rd_entry_o
);
  dir_entry_t ent_q [ENTRIES];
  dir_entry_t wr_ent;
  logic       unused_wr_bits;

  assign wr_ent.present = wr_data_i[PRES_BIT];
  assign wr_ent.base    = wr_data_i[ADDR_W-1:PAGE_W];
  assign unused_wr_bits = ^{wr_data_i[PAGE_W-1:PRES_BIT+1], wr_data_i[PRES_BIT-1:SEL_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(ENTRIES); i++) ent_q[i] <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < int'(ENTRIES); i++)
        if (wr_data_i[SEL_W-1:0] == SEL_W'(i)) ent_q[i] <= wr_ent;
    end
  end

  assign rd_entry_o = ent_q[rd_idx_i];
endmodule

// File: rtl/apx_tlb.sv
module apx_tlb #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned TAG_W   = 20,
  parameter int unsigned DATA_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] hit_data_o,
  input  logic              fill_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i
);
  localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [DATA_W-1:0]  dat_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q;
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_cmp
    assign match[g] = vld_q[g] && (tag_q[g] == lk_tag_i);
  end

  assign hit_o = |match;

  always_comb begin
    hit_data_o = '0;
    for (int i = 0; i < int'(ENTRIES); i++)
      if (match[i]) hit_data_o = hit_data_o | dat_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      ptr_q <= '0;
      for (int i = 0; i < int'(ENTRIES); i++) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else if (flush_i) begin
      vld_q <= '0;
    end else if (fill_i) begin
      vld_q[ptr_q] <= 1'b1;
      tag_q[ptr_q] <= fill_tag_i;
      dat_q[ptr_q] <= fill_data_i;
      ptr_q        <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/aperture_xlat.sv
module aperture_xlat
  import apx_pkg::*;
#(
  parameter int unsigned DIR_ENTRIES = 64,
  parameter int unsigned TLB_ENTRIES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] aper_base_i,
  input  logic [7:0]  aper_code_i,
  input  logic        dir_wr_i,
  input  logic [31:0] dir_wdata_i,
  input  logic        ctl_wr_i,
  input  logic [31:0] ctl_wdata_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_addr_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_addr_o,
  output logic        rsp_fault_o,
  output logic        rsp_range_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i
);
  localparam int unsigned IDX_W = $clog2(DIR_ENTRIES);
  localparam int unsigned ENT_W = DIR_LSB - PAGE_W;

  walk_state_e         state_q;
  logic                in_range;
  logic [IDX_W-1:0]    dir_idx;
  dir_entry_t          dir_ent;
  logic                tlb_hit;
  logic [VPN_W-1:0]    tlb_frame;
  logic                tlb_fill;
  logic                flush;
  logic                ctl_last_q;
  logic                accept;
  logic [ADDR_W-1:0]   pend_q;
  logic                rsp_valid_q, rsp_fault_q, rsp_range_q;
  logic [ADDR_W-1:0]   rsp_addr_q;
  logic                mem_req_q;
  logic [ADDR_W-1:0]   mem_addr_q;
  logic                unused_bits;

  assign unused_bits = ^{aper_base_i[DIR_LSB-1:0], ctl_wdata_i[31:FLUSH_BIT+1],
                         ctl_wdata_i[FLUSH_BIT-1:0], mem_rdata_i[PAGE_W-1:1]};

  apx_window #(.DIR_ENTRIES(DIR_ENTRIES)) i_window (
    .code_i     (aper_code_i),
    .base_hi_i  (aper_base_i[ADDR_W-1:DIR_LSB]),
    .addr_hi_i  (req_addr_i[ADDR_W-1:DIR_LSB]),
    .in_range_o (in_range),
    .dir_idx_o  (dir_idx)
  );

  apx_dir #(.ENTRIES(DIR_ENTRIES)) i_dir (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (dir_wr_i),
    .wr_data_i  (dir_wdata_i),
    .rd_idx_i   (dir_idx),
    .rd_entry_o (dir_ent)
  );

  apx_tlb #(.ENTRIES(TLB_ENTRIES), .TAG_W(VPN_W), .DATA_W(VPN_W)) i_tlb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .lk_tag_i    (req_addr_i[ADDR_W-1:PAGE_W]),
    .hit_o       (tlb_hit),
    .hit_data_o  (tlb_frame),
    .fill_i      (tlb_fill),
    .fill_tag_i  (pend_q[ADDR_W-1:PAGE_W]),
    .fill_data_i (mem_rdata_i[ADDR_W-1:PAGE_W])
  );

  // flush fires on a clear-to-set transition of the control bit
  assign flush = ctl_wr_i && ctl_wdata_i[FLUSH_BIT] && !ctl_last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_last_q <= 1'b0;
    else if (ctl_wr_i) ctl_last_q <= ctl_wdata_i[FLUSH_BIT];
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign tlb_fill    = (state_q == ST_WALK) && mem_rvalid_i && mem_rdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pend_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_range_q <= 1'b0;
      rsp_addr_q  <= '0;
      mem_req_q   <= 1'b0;
      mem_addr_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            rsp_fault_q <= 1'b0;
            rsp_range_q <= 1'b0;
            rsp_addr_q  <= '0;
            if (!in_range) begin
              rsp_valid_q <= 1'b1;
              rsp_range_q <= 1'b1;
            end else if (tlb_hit) begin
              rsp_valid_q <= 1'b1;
              rsp_addr_q  <= {tlb_frame, req_addr_i[PAGE_W-1:0]};
            end else if (!dir_ent.present) begin
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b1;
            end else begin
              state_q    <= ST_WALK;
              pend_q     <= req_addr_i;
              mem_req_q  <= 1'b1;
              mem_addr_q <= {dir_ent.base, req_addr_i[PAGE_W+ENT_W-1:PAGE_W], 2'b00};
            end
          end
        end
        ST_WALK: begin
          if (mem_rvalid_i) begin
            state_q     <= ST_IDLE;
            mem_req_q   <= 1'b0;
            rsp_valid_q <= 1'b1;
            rsp_range_q <= 1'b0;
            if (mem_rdata_i[0]) begin
              rsp_fault_q <= 1'b0;
              rsp_addr_q  <= {mem_rdata_i[ADDR_W-1:PAGE_W], pend_q[PAGE_W-1:0]};
            end else begin
              rsp_fault_q <= 1'b1;
              rsp_addr_q  <= '0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_addr_o  = rsp_addr_q;
  assign rsp_fault_o = rsp_fault_q;
  assign rsp_range_o = rsp_range_q;
  assign mem_req_o   = mem_req_q;
  assign mem_addr_o  = mem_addr_q;
endmodule

// File: rtl/apx_checker.sv
module apx_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        rsp_valid_o,
  input logic [31:0] rsp_addr_o,
  input logic        rsp_fault_o,
  input logic        rsp_range_o,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_rvalid_i
);
  a_r7_ready_low_in_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  a_r7_read_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  a_r7_read_from_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(req_valid_i && req_ready_o));

  a_r4_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !(rsp_fault_o && rsp_range_o));

  a_r6_fault_zero_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_fault_o || rsp_range_o) |-> rsp_addr_o == 32'h0);

  a_r10_walk_response: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rvalid_i |=> rsp_valid_o && req_ready_o);

  a_r10_accept_progress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_valid_o || mem_req_o);
endmodule

bind aperture_xlat apx_checker i_apx_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_addr_o   (rsp_addr_o),
  .rsp_fault_o  (rsp_fault_o),
  .rsp_range_o  (rsp_range_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i)
);

// File: tb/test_aperture_xlat.sv
module test_aperture_xlat;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] aper_base = 32'h4000_0000;
  logic [7:0]  aper_code = 8'd0;
  logic        dir_wr = 1'b0;
  logic [31:0] dir_wdata = '0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic        rsp_fault;
  logic        rsp_range;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_cmp = 0;
  int n_mis = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  aperture_xlat i_aperture_xlat (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .aper_base_i  (aper_base),
    .aper_code_i  (aper_code),
    .dir_wr_i     (dir_wr),
    .dir_wdata_i  (dir_wdata),
    .ctl_wr_i     (ctl_wr),
    .ctl_wdata_i  (ctl_wdata),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .req_addr_i   (req_addr),
    .rsp_valid_o  (rsp_valid),
    .rsp_addr_o   (rsp_addr),
    .rsp_fault_o  (rsp_fault),
    .rsp_range_o  (rsp_range),
    .mem_req_o    (mem_req),
    .mem_addr_o   (mem_addr),
    .mem_rvalid_i (mem_rvalid),
    .mem_rdata_i  (mem_rdata)
  );

  // kind: 0 translated, 1 fault, 2 out of range
  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] md;
    logic        walk;
    logic [31:0] maddr;
    logic [1:0]  kind;
    logic [31:0] eaddr;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{32'h4000_1234, 32'h8765_4001, 1'b1, 32'h0012_3004, 2'd0, 32'h8765_4234}, // R2 R6 dir 0
    '{32'h4140_5FF8, 32'h1111_1FFF, 1'b1, 32'h00AB_C014, 2'd0, 32'h1111_1FF8}, // R2 R6 dir 5
    '{32'h4FFF_F00C, 32'h0000_2001, 1'b1, 32'h7FFF_FFFC, 2'd0, 32'h0000_200C}, // R2 last dir
    '{32'h4000_1234, 32'h0,         1'b0, 32'h0,         2'd0, 32'h8765_4234}, // R8 hit
    '{32'h4080_0000, 32'h0,         1'b0, 32'h0,         2'd1, 32'h0},         // R5 dir absent
    '{32'h3FFF_FFFC, 32'h0,         1'b0, 32'h0,         2'd2, 32'h0},         // R4 below base
    '{32'h5000_0000, 32'h0,         1'b0, 32'h0,         2'd2, 32'h0},         // R4 past end
    '{32'h4000_2000, 32'h0000_5000, 1'b1, 32'h0012_3008, 2'd1, 32'h0},         // R6 entry invalid
    '{32'h4000_2000, 32'h0000_6001, 1'b1, 32'h0012_3008, 2'd0, 32'h0000_6000}  // R6 fault not cached
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic dwr(input logic [31:0] v);
    @(negedge clk); dir_wr = 1'b1; dir_wdata = v;
    @(negedge clk); dir_wr = 1'b0;
  endtask

  task automatic cwr(input logic [31:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic xact(input logic [31:0] a, input logic [31:0] md,
                      output logic walked, output logic [31:0] maddr,
                      output logic rv, output logic [31:0] ra,
                      output logic rf, output logic rr);
    walked = 1'b0;
    maddr  = '0;
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    @(negedge clk); req_valid = 1'b0;
    if (mem_req) begin
      walked = 1'b1;
      maddr  = mem_addr;
      chk("R7 ready low during walk", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
      chk("R7 read request held", {31'b0, mem_req}, 32'd1);
      mem_rvalid = 1'b1; mem_rdata = md;
      @(negedge clk);
      mem_rvalid = 1'b0;
    end
    rv = rsp_valid; ra = rsp_addr; rf = rsp_fault; rr = rsp_range;
  endtask

  task automatic run(input string tag, input vec_t v);
    logic w, rv, rf, rr;
    logic [31:0] ma, ra;
    xact(v.addr, v.md, w, ma, rv, ra, rf, rr);
    chk({tag, " R10 response valid"}, {31'b0, rv}, 32'd1);
    chk({tag, " walk taken"}, {31'b0, w}, {31'b0, v.walk});
    if (v.walk) chk({tag, " R2 table address"}, ma, v.maddr);
    chk({tag, " fault flag"}, {31'b0, rf}, {31'b0, v.kind == 2'd1});
    chk({tag, " R4 range flag"}, {31'b0, rr}, {31'b0, v.kind == 2'd2});
    chk({tag, " R6 address"}, ra, v.eaddr);
  endtask

  function automatic vec_t mk(input logic [31:0] a, input logic [31:0] md, input logic w,
                              input logic [31:0] ma, input logic [1:0] k, input logic [31:0] ea);
    vec_t v;
    v.addr = a; v.md = md; v.walk = w; v.maddr = ma; v.kind = k; v.eaddr = ea;
    return v;
  endfunction

  initial begin : wd
    repeat (WD_CYCLES) @(posedge clk);
    n_cmp++; n_mis++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R10 reset mem_req", {31'b0, mem_req}, 32'd0);
    chk("R10 reset ready", {31'b0, req_ready}, 32'd1);
    rst_n = 1'b1;

    // R1 directory loads; attribute and reserved bits set on entry 5 are ignored
    dwr(32'h0012_3100);
    dwr(32'h00AB_CFC5);
    dwr(32'h7FFF_F13F);

    for (int i = 0; i < NVEC; i++) run($sformatf("vec%0d", i), VECS[i]);

    // R8 round robin: fifth page evicts the oldest fill
    run("R8 fill slot0", mk(32'h4000_3000, 32'h0000_7001, 1'b1, 32'h0012_300C, 2'd0, 32'h0000_7000));
    run("R8 kept entry", mk(32'h4FFF_F00C, 32'h0, 1'b0, 32'h0, 2'd0, 32'h0000_200C));
    run("R8 evicted entry", mk(32'h4000_1234, 32'h8765_4001, 1'b1, 32'h0012_3004, 2'd0, 32'h8765_4234));

    // R9 flush rules
    cwr(32'h0000_2200);
    run("R9 clear alone keeps", mk(32'h4FFF_F00C, 32'h0, 1'b0, 32'h0, 2'd0, 32'h0000_200C));
    cwr(32'h0000_2280);
    run("R9 clear-to-set flushes", mk(32'h4FFF_F00C, 32'h0000_2001, 1'b1, 32'h7FFF_FFFC, 2'd0, 32'h0000_200C));
    cwr(32'h0000_2280);
    run("R9 set again keeps", mk(32'h4FFF_F00C, 32'h0, 1'b0, 32'h0, 2'd0, 32'h0000_200C));

    // R1 invalidate by writing only the index, then load entry 2
    dwr(32'h0000_0000);
    run("R1 R5 cleared entry", mk(32'h4000_4000, 32'h0, 1'b0, 32'h0, 2'd1, 32'h0));
    dwr(32'h0045_6102);
    run("R1 new entry", mk(32'h4080_0010, 32'h0009_9001, 1'b1, 32'h0045_6000, 2'd0, 32'h0009_9010));

    // R3 window sizes
    aper_code = 8'd56;
    run("R3 32M last", mk(32'h41C0_0000, 32'h0, 1'b0, 32'h0, 2'd1, 32'h0));
    run("R3 32M over", mk(32'h4200_0000, 32'h0, 1'b0, 32'h0, 2'd2, 32'h0));
    aper_code = 8'd48;
    run("R3 64M last", mk(32'h43C0_0000, 32'h0, 1'b0, 32'h0, 2'd1, 32'h0));
    run("R3 64M over", mk(32'h4400_0000, 32'h0, 1'b0, 32'h0, 2'd2, 32'h0));
    aper_code = 8'd32;
    run("R3 128M last", mk(32'h47C0_0000, 32'h0, 1'b0, 32'h0, 2'd1, 32'h0));
    run("R3 128M over", mk(32'h4800_0000, 32'h0, 1'b0, 32'h0, 2'd2, 32'h0));
    aper_code = 8'd7;
    run("R3 R4 bad code beats hit", mk(32'h4FFF_F00C, 32'h0, 1'b0, 32'h0, 2'd2, 32'h0));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule